// File: doc/BRIEF.md
# Packet Stream Replay Buffer

This block sits between a frame source and a half-duplex transmitter that detects collisions. Bytes enter on a valid/ready stream with an end-of-packet flag and leave on a second valid/ready stream of the same form. Every byte that leaves is read out of a circular RAM; there is no path that goes around the RAM. The buffer keeps the opening bytes of the current packet. If the transmitter sees an early collision it pulses `replay`, and the packet starts again from its first byte.

Three pointers run over the RAM: write, read and packet start. Each is one bit wider than the RAM address. The position of the first byte stays protected while the replay window is open. The window covers the first `KEEP` bytes read, 56 by default. After more bytes than that have been read, only a late collision can occur, so replay is ignored and protection moves up to the read pointer. The packet is released only by the consumer's `done` pulse, never by the output handshake. After the input has delivered `in_last`, the input stays closed until that `done`.

Back-pressure works as follows. `in_ready` is a register computed from the pointers the block will hold on the next cycle, including a write taking place in the current cycle. `out_valid` depends only on the pointers and never on `out_ready`.

Top module: `replay_buf`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `out_valid` and `out_last` are 0. On that first cycle `in_ready` is 1, and it is 0 while reset is high.
- R2: Bytes leave in the order they were accepted. `out_last` is 1 exactly on the final byte of the packet, and `out_valid` drops once that byte has been taken.
- R3: While `out_valid` is 1 and `out_ready` is 0, with no `replay` or `done`, the presented byte and `out_valid` stay unchanged on the next cycle.
- R4: A `replay` pulse while at most `KEEP` bytes of the packet have been read makes the first byte of the packet appear on the output on the next cycle. Any handshake in that same cycle does not count.
- R5: Once more than `KEEP` bytes of a packet have been read, `replay` is ignored until `done`, and the output carries on from the next unread byte.
- R6: While the replay window is open, no more than 2^`ADDR_W` bytes, counted from the packet's first byte, can be held. With no reads, exactly that many are accepted, and then `in_ready` stays 0.
- R7: A packet that exactly fills the RAM is still read out in full, with `out_last` on its final byte. The full-width end pointer tells a full buffer apart from an empty one.
- R8: After `in_last` is accepted, `in_ready` stays 0 until `done`. On the cycle after `done`, `in_ready` is 1 and the next packet starts at the following position.
- R9: A `done` pulse before the packet's end has been accepted has no effect. Reading continues, and replay still rewinds to the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Input byte |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Buffer will take a byte this cycle |
| in_last | input | 1 | Input byte ends the packet |
| out_data | output | DATA_W | Byte read from RAM at the read pointer |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_last | output | 1 | Output byte ends the packet |
| replay | input | 1 | Collision pulse: restart the packet |
| done | input | 1 | Consumer finished with the packet |

## Verification
The hardest case to reach is the buffer going full in the same cycle a byte is written. This needs a packet longer than the RAM while the window still pins the start pointer, and a consumer that drains more slowly than the source fills. The stimulus runs the consumer at one ready in three cycles on a 100-byte packet. It also stalls the consumer completely on 70-byte and 64-byte packets and counts the bytes accepted. Replays are injected at the first, middle and last byte of short packets, and just past the window on a long one. A scoreboard rewinds its own index to follow each replay.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
  typedef struct packed {
    logic replay;
    logic done;
  } rbuf_ctl_t;
endpackage

// File: rtl/rbuf_store.sv
module rbuf_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rbuf_ctrl.sv
module rbuf_ctrl
  import rbuf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int KEEP   = 56
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              out_ready,
  input  rbuf_ctl_t         ctl,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_last,
  output logic              wr_en,
  output logic [ADDR_W:0]   wr_ptr,
  output logic [ADDR_W:0]   rd_ptr,
  output logic [ADDR_W:0]   st_ptr,
  output logic [ADDR_W:0]   end_ptr,
  output logic              end_vld,
  output logic              win_open
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1) << ADDR_W;
  localparam logic [PTR_W-1:0] KEEP_P  = PTR_W'(KEEP);
  localparam logic [PTR_W-1:0] ONE_P   = PTR_W'(1);

  logic [PTR_W-1:0] wr_n, rd_n, st_n, end_n, base_n, gap_n;
  logic             end_vld_n, open_n, ready_n, rd_go, finish;

  assign wr_en     = in_valid && in_ready;
  assign out_valid = (rd_ptr != wr_ptr);
  assign out_last  = out_valid && end_vld && ((rd_ptr + ONE_P) == end_ptr);
  assign rd_go     = out_valid && out_ready;
  assign finish    = ctl.done && end_vld;

  always_comb begin
    wr_n      = wr_ptr + (wr_en ? ONE_P : '0);
    end_n     = end_ptr;
    end_vld_n = end_vld;
    st_n      = st_ptr;
    if (finish) begin
      end_vld_n = 1'b0;
      st_n      = end_ptr;
      rd_n      = end_ptr;
    end else begin
      if (wr_en && in_last) begin
        end_n     = wr_ptr + ONE_P;
        end_vld_n = 1'b1;
      end
      if (ctl.replay && win_open) rd_n = st_ptr;
      else                        rd_n = rd_ptr + (rd_go ? ONE_P : '0);
    end
    gap_n   = rd_n - st_n;
    open_n  = finish ? 1'b1 : (win_open && (gap_n <= KEEP_P));
    base_n  = open_n ? st_n : rd_n;
    ready_n = !end_vld_n && ((wr_n - base_n) != DEPTH_P);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      st_ptr   <= '0;
      end_ptr  <= '0;
      end_vld  <= 1'b0;
      win_open <= 1'b1;
      in_ready <= 1'b0;
    end else begin
      wr_ptr   <= wr_n;
      rd_ptr   <= rd_n;
      st_ptr   <= st_n;
      end_ptr  <= end_n;
      end_vld  <= end_vld_n;
      win_open <= open_n;
      in_ready <= ready_n;
    end
  end
endmodule

// File: rtl/replay_buf.sv
module replay_buf
  import rbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int KEEP   = 56
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_last,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  input  logic              replay,
  input  logic              done
);
  rbuf_ctl_t     ctl;
  logic          wr_en, end_vld, win_open;
  logic [ADDR_W:0] wr_ptr, rd_ptr, st_ptr, end_ptr;

  assign ctl = '{replay: replay, done: done};

  rbuf_ctrl #(.ADDR_W(ADDR_W), .KEEP(KEEP)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .out_ready(out_ready), .ctl(ctl), .in_ready(in_ready),
    .out_valid(out_valid), .out_last(out_last), .wr_en(wr_en),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .st_ptr(st_ptr), .end_ptr(end_ptr),
    .end_vld(end_vld), .win_open(win_open)
  );

  rbuf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_ptr[ADDR_W-1:0]), .wdata(in_data),
    .raddr(rd_ptr[ADDR_W-1:0]), .rdata(out_data)
  );
endmodule

// File: rtl/replay_buf_chk.sv
module replay_buf_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last,
  input logic              replay,
  input logic              done,
  input logic [ADDR_W:0]   wr_ptr,
  input logic [ADDR_W:0]   rd_ptr,
  input logic [ADDR_W:0]   st_ptr,
  input logic [ADDR_W:0]   end_ptr,
  input logic              end_vld,
  input logic              win_open
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1) << ADDR_W;

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !replay && !done |=> out_valid && $stable(out_data)); // R3
  AST_REWIND: assert property (@(posedge clk) disable iff (rst)
    replay && win_open && !(done && end_vld) |=> rd_ptr == $past(st_ptr)); // R4
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - (win_open ? st_ptr : rd_ptr)) <= DEPTH_P); // R6
  AST_END_UNREAD_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    end_vld && (rd_ptr != end_ptr) |-> out_valid); // R7
  AST_CLOSED_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    end_vld |-> !in_ready); // R8
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (rst)
    done && end_vld |=> st_ptr == $past(end_ptr) && !end_vld); // R8
  AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    done && !end_vld |=> $stable(st_ptr)); // R9
endmodule

bind replay_buf replay_buf_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_data(out_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
  .replay(replay), .done(done), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .st_ptr(st_ptr), .end_ptr(end_ptr), .end_vld(end_vld), .win_open(win_open)
);

// File: tb/replay_buf_test.sv
module replay_buf_test;
  localparam int CLK_NS = 10;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int KEEP   = 56;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DATA_W-1:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic out_ready = 1'b0, replay = 1'b0, done = 1'b0;
  logic in_ready, out_valid, out_last;
  logic [DATA_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int sent   = 0;
  logic [DATA_W-1:0] pkt [$];

  replay_buf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEEP(KEEP)) uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_last(in_last), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .replay(replay), .done(done)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Driver: pushes bytes from the expected packet into the input port
  task automatic send(input int len);
    sent = 0;
    for (int i = 0; i < len; ) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = pkt[i];
      in_last  = (i == len - 1);
      #1;
      if (in_ready) begin
        i++;
        sent++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  // Monitor/consumer: compares output with the scoreboard packet
  task automatic recv(input int len, input int rep_at, input int done_at,
                      input int hold, input int ratio);
    int  idx = 0;
    int  k = 0;
    bit  rep_used = 0, done_used = 0, chk_rewind = 0, chk_skip = 0;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      out_ready = 1'b0;
    end
    if (hold > 0) begin
      #2;
      check(sent == ((len < DEPTH) ? len : DEPTH), "R6 bytes held with no reads",
            sent, (len < DEPTH) ? len : DEPTH);
      check(!in_ready, "R6 in_ready low when full", int'(in_ready), 0);
      check(out_valid && out_data == pkt[0], "R3 first byte held under stall",
            int'(out_data), int'(pkt[0]));
      if (len == DEPTH)
        check(sent == DEPTH, "R7 full packet fully accepted", sent, DEPTH);
    end
    while (idx < len) begin
      @(negedge clk);
      k++;
      if (chk_rewind) begin
        check(out_valid && out_data == pkt[0], "R4 rewind to first byte",
              int'(out_data), int'(pkt[0]));
        chk_rewind = 0;
      end
      if (chk_skip) begin
        check(out_valid && out_data == pkt[idx], "R5 late replay ignored",
              int'(out_data), int'(pkt[idx]));
        chk_skip = 0;
      end
      out_ready = (k % ratio == 0);
      replay = 1'b0;
      done   = 1'b0;
      if (!rep_used && idx == rep_at && out_valid) begin
        replay = 1'b1;
        rep_used = 1;
      end
      if (!done_used && done_at >= 0 && idx == done_at) begin
        done = 1'b1;
        done_used = 1;
      end
      #1;
      if (replay && idx <= KEEP) begin
        idx = 0;
        chk_rewind = 1;
      end else begin
        if (replay) chk_skip = 1;
        if (out_valid && out_ready) begin
          check(out_data == pkt[idx], done ? "R9 data after early done" : "R2 data order",
                int'(out_data), int'(pkt[idx]));
          check(out_last == (idx == len - 1), (len == DEPTH) ? "R7 last flag" : "R2 last flag",
                int'(out_last), int'(idx == len - 1));
          idx++;
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    replay    = 1'b0;
    check(!out_valid, "R2 valid drops after final byte", int'(out_valid), 0);
    check(!in_ready, "R8 input closed before done", int'(in_ready), 0);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    #1;
    check(in_ready, "R8 input reopens after done", int'(in_ready), 1);
  endtask

  task automatic run_pkt(input int len, input int rep_at, input int done_at,
                         input int hold, input int ratio, input int seed);
    pkt.delete();
    for (int i = 0; i < len; i++) pkt.push_back(DATA_W'(seed * 7 + i * 13 + 5));
    fork
      send(len);
      recv(len, rep_at, done_at, hold, ratio);
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!in_ready && !out_valid, "R1 idle during reset", int'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(in_ready, "R1 in_ready after reset", int'(in_ready), 1);
    check(!out_valid && !out_last, "R1 output idle after reset", int'(out_valid), 0);

    run_pkt(20,  0,  -1, 0,  1, 1);   // R4 replay on first byte
    run_pkt(54,  27, -1, 0,  2, 2);   // R4 replay mid packet
    run_pkt(54,  53, -1, 0,  3, 3);   // R4 replay on last byte of short packet
    run_pkt(100, 60, -1, 0,  3, 4);   // R5 late replay, R6 full-next-cycle
    run_pkt(100, 10, 5,  0,  2, 5);   // R9 early done then replay
    run_pkt(70,  -1, -1, 80, 1, 6);   // R6 stalled consumer
    run_pkt(64,  -1, -1, 80, 2, 7);   // R7 packet fills RAM
    run_pkt(1,   0,  -1, 0,  1, 8);   // R2 single-byte packet

    summary();
    $finish;
  end
endmodule